// File: doc/BRIEF.md
# Shared Bus Arbiter with Ownership Hold Rules

This block decides which of three on-chip masters drives a shared internal bus. The masters are a CPU, a descriptor-driven transfer controller and a DMA engine. It also lends the external bus to an off-chip requester. Each master raises a request, marks the last clock of each of its bus cycles with a cycle-end strobe, and reports what kind of transfer it is in. At every cycle boundary of the current owner, the arbiter uses that report to keep the owner on the bus or to hand the bus to another master. Ownership therefore follows transfer phases and modes rather than single cycles.

Two configuration inputs tune the behaviour. One forces the DMA engine to give up the bus after every cycle, even in block or burst mode. The other, together with an interrupt-side enable, allows the external bus to be lent out. Lending waits until the external cycle in progress has finished. While the bus is lent, an acknowledge is held and DMA access to external space is stalled. The grant outputs are registered and one-hot. A change of owner becomes visible on the clock after the deciding boundary.

Top module: `bus_hold_arbiter`

## Requirements
- R1: Reset (asynchronous, active low) leaves the CPU granted, `extRelAck` low and `dmaExtGo` low.
- R2: Exactly one of `cpuGnt`, `xfcGnt`, `dmaGnt` is high at all times. The grant changes only on the clock after a boundary of the current owner. A boundary is a cycle where the owner's cycle-end strobe is high or its request is low.
- R3: At a boundary where the owner does not keep the bus, the winner is the highest-priority requester, in the order DMA, then transfer controller, then CPU. The releasing owner is skipped when any other master requests. If nobody requests, the CPU gets the bus.
- R4: The transfer controller keeps the bus at a boundary while it requests, `xfcRunDone` is low, and `xfcPhase` is 1 (descriptor read), 2 (first data transfer) or 3 (descriptor write-back). Phase 0 (any other transfer) or `xfcRunDone` high releases it.
- R5: The DMA engine keeps the bus at a boundary while it requests and `dmaDualRd` is high, marking a dual-address read whose write follows. This holds whatever the configuration and any external request.
- R6: In block mode (`dmaMode`=1) or burst mode (`dmaMode`=2), the DMA engine keeps the bus only when `cfgSplitDma` is 0 and no external release request is pending.
- R7: In single mode (`dmaMode`=0) with `dmaDualRd` low, the DMA engine releases the bus at every boundary.
- R8: An external release request is pending when `extReqN` is 0, `cfgRelEn` is 1 and `cfgIrqEn` is 1. `extRelAck` rises on the clock after a cycle in which the request is pending and `extCycBusy` is 0. It never rises while the external cycle is busy.
- R9: Once high, `extRelAck` stays high while `extReqN` is 0, whatever the enables do. It falls on the clock after `extReqN` returns to 1.
- R10: `dmaExtGo` (combinational) is high only when the DMA engine is granted, `dmaExtReq` is high, `extRelAck` is low and no external release request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | CPU bus request |
| cpuCycEnd | input | 1 | CPU last clock of a bus cycle |
| xfcReq | input | 1 | Transfer controller request |
| xfcPhase | input | 2 | Transfer controller phase: 0 other, 1 descriptor read, 2 first data, 3 write-back |
| xfcRunDone | input | 1 | Transfer controller's consecutive run is complete |
| xfcCycEnd | input | 1 | Transfer controller last clock of a bus cycle |
| dmaReq | input | 1 | DMA request |
| dmaMode | input | 2 | DMA mode: 0 single, 1 block, 2 burst |
| dmaDualRd | input | 1 | DMA dual-address read with its write still to come |
| dmaCycEnd | input | 1 | DMA last clock of a bus cycle |
| dmaExtReq | input | 1 | DMA wants external space |
| cfgSplitDma | input | 1 | 1: DMA gives up the bus after each block/burst cycle |
| cfgRelEn | input | 1 | External bus lending enable |
| cfgIrqEn | input | 1 | Interrupt-side enable for the external request pin |
| extReqN | input | 1 | Off-chip bus request, active low |
| extCycBusy | input | 1 | External bus cycle in progress |
| cpuGnt | output | 1 | CPU grant |
| xfcGnt | output | 1 | Transfer controller grant |
| dmaGnt | output | 1 | DMA grant |
| extRelAck | output | 1 | External bus lent to the off-chip requester |
| dmaExtGo | output | 1 | DMA request forwarded to the external arbiter |

## Verification
Two functions can meet in one cycle: a DMA hold decision and a pending external release request. The bench makes them coincide twice while the external cycle is still busy. The first time, a dual-address read must keep the DMA engine on the bus. The second time, a burst cycle must give the bus up to the transfer controller, because the pending request blocks the burst hold. In both cycles `dmaExtGo` must stay low and `extRelAck` must not rise until `extCycBusy` drops.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int NUM_MST = 3;
  localparam int MST_CPU = 0;
  localparam int MST_XFC = 1;
  localparam int MST_DMA = 2;

  localparam int PH_W   = 2;
  localparam int MODE_W = 2;

  typedef enum logic [PH_W-1:0] {
    XPH_OTHER   = 2'd0,
    XPH_INFO_RD = 2'd1,
    XPH_FIRST   = 2'd2,
    XPH_WB      = 2'd3
  } xfcPhaseT;

  typedef enum logic [MODE_W-1:0] {
    DM_SINGLE = 2'd0,
    DM_BLOCK  = 2'd1,
    DM_BURST  = 2'd2,
    DM_RSVD   = 2'd3
  } dmaModeT;

  // strobes from control to the grant/acknowledge datapath
  typedef struct packed {
    logic               gntLoad;
    logic [NUM_MST-1:0] gntNext;
    logic               relSet;
    logic               relClr;
  } arbStrobeT;

endpackage

// File: rtl/bus_arb_ctrl.sv
module bus_arb_ctrl
  import arb_pkg::*;
#(
  parameter int NM = NUM_MST
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NM-1:0]   reqVec,
  input  logic [NM-1:0]   endVec,
  input  logic [PH_W-1:0] xfcPhase,
  input  logic            xfcRunDone,
  input  logic [MODE_W-1:0] dmaMode,
  input  logic            dmaDualRd,
  input  logic            dmaExtReq,
  input  logic            cfgSplitDma,
  input  logic            cfgRelEn,
  input  logic            cfgIrqEn,
  input  logic            extReqN,
  input  logic            extCycBusy,
  input  logic [NM-1:0]   gntIn,
  input  logic            relAckIn,
  output arbStrobeT       strb,
  output logic            dmaExtGo
);

  xfcPhaseT  phase;
  dmaModeT   mode;
  logic      extRelReq;
  logic      ownerReq;
  logic      ownerEnd;
  logic      bndry;
  logic      xfcKeep;
  logic      dmaKeep;
  logic      keep;
  logic [NM-1:0] cand;
  logic [NM-1:0] pick;
  logic      found;

  assign phase = xfcPhaseT'(xfcPhase);
  assign mode  = dmaModeT'(dmaMode);

  assign extRelReq = !extReqN && cfgRelEn && cfgIrqEn;

  assign ownerReq = |(gntIn & reqVec);
  assign ownerEnd = |(gntIn & endVec);
  assign bndry    = ownerEnd || !ownerReq;

  assign xfcKeep = reqVec[MST_XFC] && !xfcRunDone && (phase != XPH_OTHER);
  assign dmaKeep = reqVec[MST_DMA] &&
                   (dmaDualRd ||
                    (((mode == DM_BLOCK) || (mode == DM_BURST)) &&
                     !cfgSplitDma && !extRelReq));

  assign keep = (gntIn[MST_XFC] && xfcKeep) || (gntIn[MST_DMA] && dmaKeep);

  // releasing owner sits out one round if anybody else wants the bus
  always_comb begin
    cand = reqVec & ~gntIn;
    if (cand == '0) cand = reqVec;
  end

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NM-1; i >= 0; i--) begin
      if (cand[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
    if (!found) pick[MST_CPU] = 1'b1;
  end

  always_comb begin
    strb.gntLoad = bndry && !keep;
    strb.gntNext = pick;
    strb.relSet  = !relAckIn && extRelReq && !extCycBusy;
    strb.relClr  = relAckIn && extReqN;
  end

  assign dmaExtGo = gntIn[MST_DMA] && dmaExtReq && !relAckIn && !extRelReq;

  AST_GNT_STABLE_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !bndry |=> $stable(gntIn)) else $error("grant moved off boundary"); // R2

  AST_XFC_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (gntIn[MST_XFC] && endVec[MST_XFC] && reqVec[MST_XFC] && !xfcRunDone &&
     (xfcPhase != 2'd0)) |=> gntIn[MST_XFC]) else $error("xfc lost bus in held phase"); // R4

  AST_DMA_DUAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (gntIn[MST_DMA] && reqVec[MST_DMA] && dmaDualRd) |=> gntIn[MST_DMA])
    else $error("dma lost bus between paired read and write"); // R5

  AST_REL_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(relAckIn) |-> !$past(extCycBusy)) else $error("release during busy cycle"); // R8

  AST_REL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (relAckIn && !extReqN) |=> relAckIn) else $error("release dropped early"); // R9

  AST_EXT_STALL: assert property (@(posedge clk) disable iff (!rstN)
    relAckIn |-> !dmaExtGo) else $error("external access while released"); // R10

endmodule

// File: rtl/bus_arb_dp.sv
module bus_arb_dp
  import arb_pkg::*;
#(
  parameter int NM = NUM_MST
) (
  input  logic          clk,
  input  logic          rstN,
  input  arbStrobeT     strb,
  output logic [NM-1:0] gntQ,
  output logic          relAckQ
);

  for (genvar g = 0; g < NM; g++) begin : g_gnt
    localparam logic RST_VAL = (g == MST_CPU);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             gntQ[g] <= RST_VAL;
      else if (strb.gntLoad) gntQ[g] <= strb.gntNext[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            relAckQ <= 1'b0;
    else if (strb.relSet) relAckQ <= 1'b1;
    else if (strb.relClr) relAckQ <= 1'b0;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(gntQ) == 1) else $error("grant not one-hot"); // R2

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuCycEnd,
  input  logic       xfcReq,
  input  logic [1:0] xfcPhase,
  input  logic       xfcRunDone,
  input  logic       xfcCycEnd,
  input  logic       dmaReq,
  input  logic [1:0] dmaMode,
  input  logic       dmaDualRd,
  input  logic       dmaCycEnd,
  input  logic       dmaExtReq,
  input  logic       cfgSplitDma,
  input  logic       cfgRelEn,
  input  logic       cfgIrqEn,
  input  logic       extReqN,
  input  logic       extCycBusy,
  output logic       cpuGnt,
  output logic       xfcGnt,
  output logic       dmaGnt,
  output logic       extRelAck,
  output logic       dmaExtGo
);

  logic [NUM_MST-1:0] reqVec;
  logic [NUM_MST-1:0] endVec;
  logic [NUM_MST-1:0] gnt;
  logic               relAck;
  arbStrobeT          strb;

  always_comb begin
    reqVec          = '0;
    endVec          = '0;
    reqVec[MST_CPU] = cpuReq;
    reqVec[MST_XFC] = xfcReq;
    reqVec[MST_DMA] = dmaReq;
    endVec[MST_CPU] = cpuCycEnd;
    endVec[MST_XFC] = xfcCycEnd;
    endVec[MST_DMA] = dmaCycEnd;
  end

  bus_arb_ctrl #(.NM(NUM_MST)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqVec     (reqVec),
    .endVec     (endVec),
    .xfcPhase   (xfcPhase),
    .xfcRunDone (xfcRunDone),
    .dmaMode    (dmaMode),
    .dmaDualRd  (dmaDualRd),
    .dmaExtReq  (dmaExtReq),
    .cfgSplitDma(cfgSplitDma),
    .cfgRelEn   (cfgRelEn),
    .cfgIrqEn   (cfgIrqEn),
    .extReqN    (extReqN),
    .extCycBusy (extCycBusy),
    .gntIn      (gnt),
    .relAckIn   (relAck),
    .strb       (strb),
    .dmaExtGo   (dmaExtGo)
  );

  bus_arb_dp #(.NM(NUM_MST)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .gntQ   (gnt),
    .relAckQ(relAck)
  );

  assign cpuGnt    = gnt[MST_CPU];
  assign xfcGnt    = gnt[MST_XFC];
  assign dmaGnt    = gnt[MST_DMA];
  assign extRelAck = relAck;

endmodule

// File: tb/test_bus_hold_arbiter.sv
module test_bus_hold_arbiter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 0, cpuCycEnd = 0, xfcReq = 0, xfcRunDone = 0, xfcCycEnd = 0;
  logic [1:0] xfcPhase = 0, dmaMode = 0;
  logic dmaReq = 0, dmaDualRd = 0, dmaCycEnd = 0, dmaExtReq = 0;
  logic cfgSplitDma = 0, cfgRelEn = 0, cfgIrqEn = 0, extReqN = 1, extCycBusy = 0;
  logic cpuGnt, xfcGnt, dmaGnt, extRelAck, dmaExtGo;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  bus_hold_arbiter i_bus_hold_arbiter (.*);

  typedef struct packed {
    logic cReq; logic cEnd;
    logic xReq; logic [1:0] xPh; logic xDone; logic xEnd;
    logic dReq; logic [1:0] dMode; logic dDual; logic dEnd; logic split;
    logic [2:0] gnt;   // {dma,xfc,cpu}
    logic [3:0] req;
  } vecT;

  localparam int NV = 17;
  localparam vecT TBL [NV] = '{
    '{0,0, 1,2'd1,0,0, 0,2'd0,0,0,0, 3'b010, 4'd3}, // R3 idle cpu yields
    '{0,0, 1,2'd1,0,1, 1,2'd0,0,0,0, 3'b010, 4'd4}, // R4 info read hold
    '{0,0, 1,2'd2,0,0, 1,2'd0,0,0,0, 3'b010, 4'd2}, // R2 no boundary
    '{0,0, 1,2'd3,0,1, 1,2'd0,0,0,0, 3'b010, 4'd4}, // R4 write-back hold
    '{0,0, 1,2'd3,1,1, 1,2'd0,0,0,0, 3'b100, 4'd4}, // R4 run done releases
    '{0,0, 1,2'd0,0,0, 1,2'd2,0,1,0, 3'b100, 4'd6}, // R6 burst hold
    '{0,0, 1,2'd0,0,0, 1,2'd2,0,1,1, 3'b010, 4'd6}, // R6 split releases
    '{0,0, 1,2'd0,0,1, 1,2'd1,0,0,0, 3'b100, 4'd4}, // R4 phase 0 releases
    '{1,0, 0,2'd0,0,0, 1,2'd1,0,1,0, 3'b100, 4'd6}, // R6 block hold
    '{1,0, 0,2'd0,0,0, 1,2'd0,0,1,0, 3'b001, 4'd7}, // R7 single releases
    '{1,0, 0,2'd0,0,0, 1,2'd0,0,0,0, 3'b001, 4'd2}, // R2 cpu mid-cycle
    '{1,1, 1,2'd0,0,0, 1,2'd0,0,0,0, 3'b100, 4'd3}, // R3 dma top priority
    '{1,0, 1,2'd0,0,0, 1,2'd0,1,1,1, 3'b100, 4'd5}, // R5 dual read hold
    '{1,0, 1,2'd0,0,0, 1,2'd0,0,0,0, 3'b100, 4'd2}, // R2 dma mid-cycle
    '{1,0, 1,2'd0,0,0, 0,2'd0,0,0,0, 3'b010, 4'd3}, // R3 xfc over cpu
    '{0,0, 0,2'd0,0,0, 0,2'd0,0,0,0, 3'b001, 4'd3}, // R3 default cpu
    '{1,1, 0,2'd0,0,0, 0,2'd0,0,0,0, 3'b001, 4'd3}  // R3 cpu alone re-wins
  };

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] g3();
    return {dmaGnt, xfcGnt, cpuGnt};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 reset grant", g3(), 3'b001);
    chk("R1 reset ack/go", {1'b0, extRelAck, dmaExtGo}, 3'b000);
    rstN = 1'b1;
    step();

    for (int k = 0; k < NV; k++) begin
      cpuReq = TBL[k].cReq;  cpuCycEnd = TBL[k].cEnd;
      xfcReq = TBL[k].xReq;  xfcPhase = TBL[k].xPh;
      xfcRunDone = TBL[k].xDone; xfcCycEnd = TBL[k].xEnd;
      dmaReq = TBL[k].dReq;  dmaMode = TBL[k].dMode;
      dmaDualRd = TBL[k].dDual; dmaCycEnd = TBL[k].dEnd;
      cfgSplitDma = TBL[k].split;
      step();
      chk($sformatf("R%0d vector %0d", TBL[k].req, k), g3(), TBL[k].gnt);
    end

    // R10: DMA granted, no external activity -> forwarded
    cpuReq = 0; cpuCycEnd = 0; xfcReq = 0; cfgSplitDma = 0;
    dmaReq = 1; dmaMode = 2'd0; dmaDualRd = 0; dmaCycEnd = 0; dmaExtReq = 1;
    step();
    chk("R10 dma owns", g3(), 3'b100);
    chk("R10 go forwarded", {2'b00, dmaExtGo}, 3'b001);

    // same cycle: dual read hold with external request pending, cycle busy
    xfcReq = 1; extReqN = 0; cfgRelEn = 1; cfgIrqEn = 1; extCycBusy = 1;
    dmaDualRd = 1; dmaCycEnd = 1;
    #1;
    chk("R10 pending blocks go", {2'b00, dmaExtGo}, 3'b000);
    step();
    chk("R5 dual hold beats pending", g3(), 3'b100);
    chk("R8 no ack while busy", {2'b00, extRelAck}, 3'b000);

    // burst hold denied by pending external request
    dmaDualRd = 0; dmaMode = 2'd2;
    step();
    chk("R6 pending ext breaks burst hold", g3(), 3'b010);
    chk("R8 still busy no ack", {2'b00, extRelAck}, 3'b000);

    extCycBusy = 0;
    step();
    chk("R8 ack after cycle ends", {2'b00, extRelAck}, 3'b001);

    // enable dropped, pin still low: ack held; DMA back on bus is stalled
    cfgRelEn = 0; xfcReq = 0; dmaMode = 2'd0; dmaCycEnd = 0;
    step();
    chk("R9 ack held", {2'b00, extRelAck}, 3'b001);
    chk("R3 dma regains", g3(), 3'b100);
    chk("R10 stalled while released", {2'b00, dmaExtGo}, 3'b000);

    extReqN = 1;
    step();
    chk("R9 ack drops", {2'b00, extRelAck}, 3'b000);
    chk("R10 go resumes", {2'b00, dmaExtGo}, 3'b001);

    // gating: interrupt enable off, then release enable off
    extReqN = 0; cfgRelEn = 1; cfgIrqEn = 0;
    step(); step();
    chk("R8 irq enable gates", {2'b00, extRelAck}, 3'b000);
    cfgRelEn = 0; cfgIrqEn = 1;
    step();
    chk("R8 release enable gates", {2'b00, extRelAck}, 3'b000);

    // R1 reset from a non-default owner
    extReqN = 1;
    rstN = 0;
    #1;
    chk("R1 async reset grant", g3(), 3'b001);
    chk("R1 async reset ack/go", {1'b0, extRelAck, dmaExtGo}, 3'b000);
    step();
    finish();
  end

endmodule